// File: doc/BRIEF.md
# Transmit Edge-Rate Calibration Sequencer

This block runs the automatic edge-rate calibration of a high-speed USB 2.0 transmitter. On a start pulse it powers a ring oscillator and lets it settle. It then turns on a free-running count clock, loads the measurement window into a frequency meter and enables the meter. The meter's valid flag is sampled at a fixed poll interval until it is seen or a timeout expires. The latched count is turned into a 3-bit slew control code, and the measurement resources are shut down in a fixed order.

The code is the rounded value of (reference MHz × coefficient × window) / count / 1000. It is computed with a multi-cycle restoring divider and a threshold encoder that saturates at 7. A zero count skips the division and selects a fallback code of 3. A nonzero forced code bypasses the whole measurement. The reference frequency (26 MHz in a typical setup) and the coefficient (typically 17) are inputs. All delays are derived from a clock-cycles-per-microsecond parameter.

Top module: `slew_cal_seq`

## Requirements
- R1: While reset is asserted and right after it, every enable is low, `code_o` is 0, `done_o` is low and `fm_window_o` is 0.
- R2: A start pulse in idle with a nonzero `force_code_i` sets `code_o` to that value and pulses `done_o` for one cycle, both in the cycle after the start edge. No enable is raised.
- R3: A start pulse in idle with `force_code_i` equal to 0 raises `osc_en_o`. `frck_en_o` rises SETTLE_US×CYC_PER_US cycles later. `fm_window_o` is loaded with WINDOW (1024) one cycle after that, and `fm_en_o` rises one cycle after the load.
- R4: `fm_valid_i` is sampled only every POLL_US×CYC_PER_US cycles after the meter is enabled. A valid pulse that falls between two sampling points has no effect. With valid held high, `fm_en_o` stays high for exactly one poll interval.
- R5: If valid is never seen, the count present on `fm_count_i` is taken at the first sampling point where at least TIMEOUT_US×CYC_PER_US cycles have elapsed since the meter was enabled.
- R6: The shutdown order is fixed. `fm_en_o` falls at the sampling point and `frck_en_o` falls one cycle later. `code_o` is written next. Then `osc_en_o` falls together with a one-cycle `done_o`.
- R7: For a nonzero count N, the code is round(ref × coef × 1024 / N / 1000), computed with the integer quotient Q = floor(ref × coef × 1024 / N) as floor((Q + 500) / 1000). At defaults, N = 302 gives 1 and N = 301 gives 2.
- R8: A zero count gives code 3, written in the same cycle that `frck_en_o` falls.
- R9: A computed code above 7 is clamped to 7.
- R10: A start pulse while a calibration is running is ignored.
- R11: For a nonzero count, `code_o` changes NUM_W+1 cycles after `frck_en_o` falls, where NUM_W = 2×PAR_W + log2(WINDOW) + 1. This is 27 at the defaults.
- R12: `code_o` holds its value between calibrations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| force_code_i | input | CODE_W (3) | Forced code; 0 selects measurement |
| ref_mhz_i | input | PAR_W (8) | Reference frequency in MHz |
| coef_i | input | PAR_W (8) | Edge-rate coefficient |
| fm_valid_i | input | 1 | Frequency meter result valid |
| fm_count_i | input | CNT_W (24) | Frequency meter count |
| osc_en_o | output | 1 | Ring oscillator enable |
| frck_en_o | output | 1 | Free-running count clock enable |
| fm_window_o | output | log2(WINDOW)+1 (11) | Meter window length |
| fm_en_o | output | 1 | Frequency meter enable |
| code_o | output | CODE_W (3) | Slew control code |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The computation is tried with counts whose quotients land just below and just above a rounding threshold (302 and 301), so a wrong rounding offset or a truncating division is told apart from a correct one. A count small enough to exceed 7 separates clamping from wrap-around, and a zero count separates the fallback path from a divide by zero. The poll logic is tried with valid held high, never raised, and raised only between sampling points, which separates continuous sampling from interval sampling and exposes a wrong timeout length. A forced code, a start pulse injected mid-run and a changed reference and coefficient separate the bypass, the busy guard and the use of the programmable inputs from hard-wired values.

// File: rtl/slew_cal_pkg.sv
package slew_cal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_SETTLE, ST_LOAD, ST_ARM, ST_POLL, ST_FRCK_OFF, ST_DIV, ST_OSC_OFF
    } cal_st_e;
endpackage

// File: rtl/slew_cal_div.sv
module slew_cal_div #(
    parameter int NUM_W = 27,
    parameter int DEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quot_o
);
    localparam int IT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic [NUM_W-1:0] work;
        logic [DEN_W-1:0] rem;
        logic [DEN_W-1:0] den;
        logic [IT_W-1:0]  it;
        logic             done;
    } div_t;

    div_t q, d;
    logic [DEN_W:0] trial;
    logic [DEN_W:0] diff;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem, q.work[NUM_W-1]};
        diff   = trial - {1'b0, q.den};
        if (start_i) begin
            d.work = num_i;
            d.rem  = '0;
            d.den  = den_i;
            d.it   = IT_W'(NUM_W);
        end else if (q.it != '0) begin
            if (trial >= {1'b0, q.den}) begin
                d.rem  = diff[DEN_W-1:0];
                d.work = {q.work[NUM_W-2:0], 1'b1};
            end else begin
                d.rem  = trial[DEN_W-1:0];
                d.work = {q.work[NUM_W-2:0], 1'b0};
            end
            d.it = q.it - IT_W'(1);
            if (q.it == IT_W'(1)) d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign quot_o = q.work;
endmodule

// File: rtl/slew_cal_round.sv
module slew_cal_round #(
    parameter int Q_W    = 27,
    parameter int SCALE  = 1000,
    parameter int CODE_W = 3
) (
    input  logic [Q_W-1:0]    quot_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int MAX_CODE = (1 << CODE_W) - 1;

    logic [MAX_CODE-1:0] hit;

    for (genvar k = 1; k <= MAX_CODE; k++) begin : g_thr
        localparam longint THR = longint'(k) * SCALE - SCALE / 2;
        assign hit[k-1] = ({{(64-Q_W){1'b0}}, quot_i} >= 64'(THR));
    end

    always_comb begin
        code_o = '0;
        for (int i = 0; i < MAX_CODE; i++) begin
            code_o = code_o + CODE_W'(hit[i]);
        end
    end
endmodule

// File: rtl/slew_cal_seq.sv
module slew_cal_seq
    import slew_cal_pkg::*;
#(
    parameter int CYC_PER_US = 250,
    parameter int SETTLE_US  = 1,
    parameter int POLL_US    = 10,
    parameter int TIMEOUT_US = 200,
    parameter int WINDOW     = 1024,
    parameter int SCALE      = 1000,
    parameter int FALLBACK   = 3,
    parameter int PAR_W      = 8,
    parameter int CNT_W      = 24,
    parameter int CODE_W     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [CODE_W-1:0]           force_code_i,
    input  logic [PAR_W-1:0]            ref_mhz_i,
    input  logic [PAR_W-1:0]            coef_i,
    input  logic                        fm_valid_i,
    input  logic [CNT_W-1:0]            fm_count_i,
    output logic                        osc_en_o,
    output logic                        frck_en_o,
    output logic [$clog2(WINDOW):0]     fm_window_o,
    output logic                        fm_en_o,
    output logic [CODE_W-1:0]           code_o,
    output logic                        done_o
);
    localparam int SETTLE_CYC  = SETTLE_US * CYC_PER_US;
    localparam int POLL_CYC    = POLL_US * CYC_PER_US;
    localparam int TIMEOUT_CYC = TIMEOUT_US * CYC_PER_US;
    localparam int TMR_W       = $clog2(TIMEOUT_CYC + POLL_CYC + 1);
    localparam int WIN_W       = $clog2(WINDOW) + 1;
    localparam int NUM_W       = 2 * PAR_W + WIN_W;

    typedef struct packed {
        cal_st_e           st;
        logic [TMR_W-1:0]  tmr;
        logic [TMR_W-1:0]  el;
        logic [CNT_W-1:0]  cnt;
        logic [WIN_W-1:0]  win;
        logic [CODE_W-1:0] code;
        logic              osc;
        logic              frck;
        logic              fm;
        logic              done;
    } seq_t;

    seq_t seq_q, seq_d;

    logic              div_start;
    logic              div_done;
    logic [NUM_W-1:0]  div_num;
    logic [NUM_W-1:0]  div_quot;
    logic [CODE_W-1:0] rnd_code;

    assign div_num = NUM_W'(ref_mhz_i) * NUM_W'(coef_i) * NUM_W'(WINDOW);

    slew_cal_div #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (div_num),
        .den_i   (seq_q.cnt),
        .done_o  (div_done),
        .quot_o  (div_quot)
    );

    slew_cal_round #(.Q_W(NUM_W), .SCALE(SCALE), .CODE_W(CODE_W)) u_round (
        .quot_i (div_quot),
        .code_o (rnd_code)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        div_start  = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (force_code_i != '0) begin
                        seq_d.code = force_code_i;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.osc = 1'b1;
                        seq_d.tmr = '0;
                        seq_d.st  = ST_SETTLE;
                    end
                end
            end
            ST_SETTLE: begin
                if (seq_q.tmr == TMR_W'(SETTLE_CYC - 1)) begin
                    seq_d.frck = 1'b1;
                    seq_d.st   = ST_LOAD;
                end else begin
                    seq_d.tmr = seq_q.tmr + TMR_W'(1);
                end
            end
            ST_LOAD: begin
                seq_d.win = WIN_W'(WINDOW);
                seq_d.st  = ST_ARM;
            end
            ST_ARM: begin
                seq_d.fm  = 1'b1;
                seq_d.tmr = '0;
                seq_d.el  = '0;
                seq_d.st  = ST_POLL;
            end
            ST_POLL: begin
                seq_d.el = seq_q.el + TMR_W'(1);
                if (seq_q.tmr == TMR_W'(POLL_CYC - 1)) begin
                    seq_d.tmr = '0;
                    if (fm_valid_i || (seq_q.el + TMR_W'(1) >= TMR_W'(TIMEOUT_CYC))) begin
                        seq_d.cnt = fm_count_i;
                        seq_d.fm  = 1'b0;
                        seq_d.st  = ST_FRCK_OFF;
                    end
                end else begin
                    seq_d.tmr = seq_q.tmr + TMR_W'(1);
                end
            end
            ST_FRCK_OFF: begin
                seq_d.frck = 1'b0;
                if (seq_q.cnt == '0) begin
                    seq_d.code = CODE_W'(FALLBACK);
                    seq_d.st   = ST_OSC_OFF;
                end else begin
                    div_start = 1'b1;
                    seq_d.st  = ST_DIV;
                end
            end
            ST_DIV: begin
                if (div_done) begin
                    seq_d.code = rnd_code;
                    seq_d.st   = ST_OSC_OFF;
                end
            end
            ST_OSC_OFF: begin
                seq_d.osc  = 1'b0;
                seq_d.done = 1'b1;
                seq_d.st   = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign osc_en_o    = seq_q.osc;
    assign frck_en_o   = seq_q.frck;
    assign fm_window_o = seq_q.win;
    assign fm_en_o     = seq_q.fm;
    assign code_o      = seq_q.code;
    assign done_o      = seq_q.done;
endmodule

// File: rtl/slew_cal_chk.sv
module slew_cal_chk #(
    parameter int CODE_W = 3,
    parameter int WINDOW = 1024
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    osc_en_o,
    input logic                    frck_en_o,
    input logic [$clog2(WINDOW):0] fm_window_o,
    input logic                    fm_en_o,
    input logic [CODE_W-1:0]       code_o,
    input logic                    done_o
);
    localparam int WIN_W = $clog2(WINDOW) + 1;

    AST_FM_NEEDS_FRCK: assert property (@(posedge clk) disable iff (!rst_n)
        fm_en_o |-> (frck_en_o && osc_en_o)); // R3
    AST_FM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        fm_en_o |-> (fm_window_o == WIN_W'(WINDOW))); // R3
    AST_FRCK_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        frck_en_o |-> osc_en_o); // R6
    AST_FRCK_AFTER_FM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frck_en_o) |-> $past(!fm_en_o)); // R6
    AST_OSC_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en_o) |-> done_o); // R6
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!osc_en_o && !frck_en_o && !fm_en_o)); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R2
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> (osc_en_o || done_o)); // R12
endmodule

bind slew_cal_seq slew_cal_chk #(.CODE_W(CODE_W), .WINDOW(WINDOW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_en_o    (osc_en_o),
    .frck_en_o   (frck_en_o),
    .fm_window_o (fm_window_o),
    .fm_en_o     (fm_en_o),
    .code_o      (code_o),
    .done_o      (done_o)
);

// File: tb/sim_slew_cal_seq.sv
module sim_slew_cal_seq;
    localparam int CPU     = 4;
    localparam int S_CYC   = 1 * CPU;
    localparam int P_CYC   = 10 * CPU;
    localparam int T_CYC   = 200 * CPU;
    localparam int DIV_LAT = 27; // R11: 2*8 + 10 + 1

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  force_code_i = '0;
    logic [7:0]  ref_mhz_i = 8'd26;
    logic [7:0]  coef_i = 8'd17;
    logic        fm_valid_i = 1'b0;
    logic [23:0] fm_count_i = '0;
    logic        osc_en_o, frck_en_o, fm_en_o, done_o;
    logic [10:0] fm_window_o;
    logic [2:0]  code_o;

    always #2 clk = ~clk;

    slew_cal_seq #(.CYC_PER_US(CPU)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .force_code_i(force_code_i),
        .ref_mhz_i(ref_mhz_i), .coef_i(coef_i), .fm_valid_i(fm_valid_i),
        .fm_count_i(fm_count_i), .osc_en_o(osc_en_o), .frck_en_o(frck_en_o),
        .fm_window_o(fm_window_o), .fm_en_o(fm_en_o), .code_o(code_o), .done_o(done_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int ph = 0, m_t = 0, m_el = 0, m_cnt = 0, m_code = 0;
    bit e_osc = 0, e_frck = 0, e_fm = 0, e_done = 0;
    int e_win = 0, e_code = 0;

    function automatic int calc_code(input int rf, input int cf, input int n);
        longint qv = (longint'(rf) * cf * 1024) / n;
        longint c  = (qv + 500) / 1000;
        if (c > 7) c = 7;
        return int'(c);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; e_osc = 0; e_frck = 0; e_fm = 0; e_done = 0; e_win = 0; e_code = 0;
        end else begin
            e_done = 0;
            case (ph)
                0: if (start_i) begin
                       if (force_code_i != 0) begin e_code = force_code_i; e_done = 1; end
                       else begin e_osc = 1; m_t = 0; ph = 1; end
                   end
                1: if (m_t == S_CYC - 1) begin e_frck = 1; ph = 2; end else m_t++;
                2: begin e_win = 1024; ph = 3; end
                3: begin e_fm = 1; m_t = 0; m_el = 0; ph = 4; end
                4: begin
                       m_el++; m_t++;
                       if (m_t == P_CYC) begin
                           m_t = 0;
                           if (fm_valid_i || m_el >= T_CYC) begin
                               m_cnt = fm_count_i; e_fm = 0; ph = 5;
                           end
                       end
                   end
                5: begin
                       e_frck = 0;
                       if (m_cnt == 0) begin e_code = 3; ph = 7; end
                       else begin m_code = calc_code(ref_mhz_i, coef_i, m_cnt); m_t = 0; ph = 6; end
                   end
                6: begin m_t++; if (m_t == DIV_LAT + 1) begin e_code = m_code; ph = 7; end end
                default: begin e_osc = 0; e_done = 1; ph = 0; end
            endcase
        end
    end

    // per-cycle comparison and edge timestamps
    int cyc = 0, n_done = 0;
    int t_osc, t_frck, t_fm, t_fmf, t_frckf, t_code, t_done;
    bit osc_seen = 0;
    logic p_osc = 0, p_frck = 0, p_fm = 0;
    logic [2:0] p_code = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R3 osc_en", osc_en_o, e_osc);
            chk("R6 frck_en", frck_en_o, e_frck);
            chk("R3 window", fm_window_o, e_win);
            chk("R4 fm_en", fm_en_o, e_fm);
            chk("R7 code", code_o, e_code);
            chk("R6 done", done_o, e_done);
            if (osc_en_o && !p_osc) begin t_osc = cyc; osc_seen = 1; end
            if (frck_en_o && !p_frck) t_frck = cyc;
            if (!frck_en_o && p_frck) t_frckf = cyc;
            if (fm_en_o && !p_fm) t_fm = cyc;
            if (!fm_en_o && p_fm) t_fmf = cyc;
            if (code_o != p_code) t_code = cyc;
            if (done_o) begin t_done = cyc; n_done++; end
        end
        p_osc = osc_en_o; p_frck = frck_en_o; p_fm = fm_en_o; p_code = code_o;
    end

    always @(posedge clk) begin
        if (cyc == 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic pulse_start(input logic [2:0] fc);
        @(negedge clk);
        force_code_i = fc;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        force_code_i = '0;
    endtask

    // mode 0: valid held high, 1: never valid, 2: valid only between sampling points
    task automatic run_cal(input int cnt, input int mode, input bit poke);
        int d0 = n_done;
        fm_count_i = 24'(cnt);
        fm_valid_i = (mode == 0);
        osc_seen = 0;
        pulse_start(3'd0);
        while (!fm_en_o) @(negedge clk);
        if (mode == 2) begin
            repeat (5) @(negedge clk);
            fm_valid_i = 1'b1;
            repeat (3) @(negedge clk);
            fm_valid_i = 1'b0;
        end
        if (poke) pulse_start(3'd6);
        while (n_done == d0) @(negedge clk);
        fm_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 single done per run", n_done - d0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 osc", osc_en_o, 0);
        chk("R1 frck", frck_en_o, 0);
        chk("R1 fm", fm_en_o, 0);
        chk("R1 code", code_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 window", fm_window_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 forced code bypass
        osc_seen = 0;
        @(negedge clk);
        force_code_i = 3'd5;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        force_code_i = '0;
        chk("R2 forced code", code_o, 5);
        chk("R2 forced done", done_o, 1);
        @(negedge clk);
        chk("R2 done one cycle", done_o, 0);
        repeat (5) @(negedge clk);
        chk("R2 no oscillator", osc_seen, 0);

        // R3 R4 R6 R11 R7 count 302 -> 1
        run_cal(302, 0, 0);
        chk("R7 count 302", code_o, 1);
        chk("R3 settle length", t_frck - t_osc, S_CYC);
        chk("R3 meter after load", t_fm - t_frck, 2);
        chk("R4 held valid one interval", t_fmf - t_fm, P_CYC);
        chk("R6 frck after fm", t_frckf - t_fmf, 1);
        chk("R11 divide latency", t_code - t_frckf, DIV_LAT + 1);
        chk("R6 osc off with done", t_done - t_code, 1);

        run_cal(301, 0, 0);
        chk("R7 count 301", code_o, 2);

        run_cal(100, 0, 1);
        chk("R10 code after mid-run start", code_o, 5);

        run_cal(50, 0, 0);
        chk("R9 clamp", code_o, 7);

        run_cal(0, 0, 0);
        chk("R8 fallback", code_o, 3);
        chk("R8 fallback timing", t_code, t_frckf);

        run_cal(200, 1, 0);
        chk("R5 timeout code", code_o, 2);
        chk("R5 timeout length", t_fmf - t_fm, T_CYC);

        run_cal(1000, 2, 0);
        chk("R4 glitch ignored code", code_o, 0);
        chk("R4 glitch ignored length", t_fmf - t_fm, T_CYC);

        ref_mhz_i = 8'd20;
        coef_i = 8'd10;
        run_cal(64, 0, 0);
        chk("R7 programmed ref and coef", code_o, 3);

        repeat (50) @(negedge clk);
        chk("R12 code held", code_o, 3);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule